// File: doc/BRIEF.md
# Cascadable 1:4 Serial-to-Parallel Converter

The block turns a single-bit NRZ stream, one bit per rising edge of the bit clock, into a parallel word of `W` bits (four by default). Either a line input or a loopback input feeds the converter; a plain select pin picks between them, so a link can be exercised by wrapping a local serializer's output back in without touching the serial medium. Every `W` bit clocks the finished word is copied to a holding register that stays stable for the following `W` clocks.

Two registered clock outputs come with the word. One runs at 1/W of the bit rate and lets downstream logic sample the word. The other runs at 1/(2W) of the bit rate and marks the boundary of a double-width word. A registered serial pass-through forwards each bit after it has crossed the whole shift chain. This lets a second, higher-order instance on the same bit clock and reset collect the earlier half of a 2W-bit word. The instance fed directly from the line supplies the low bits and the chained instance supplies the high bits.

No stream handshake exists. The serial side is paced only by the bit clock and cannot be stalled. The downstream side gets no back-pressure: it must take each word within the `W` clocks before the next one replaces it. A synchronous reset clears all state so that word boundaries start from a known phase.

Top module: `ser2par_cascade`

## Requirements
- R1: In each loaded word, bit W-1 holds the earliest of its W received bits and bit 0 the latest.
- R2: The parallel output changes only at edges number W, 2W, 3W... counted from the first edge after reset, and holds its value at every other edge.
- R3: With loop_sel_i = 1 the loop_i input is converted and line_i has no effect on any output; with loop_sel_i = 0 line_i is converted and loop_i has no effect.
- R4: A change of loop_sel_i applies to the bit captured at the next rising edge.
- R5: ser_o is registered. The bit captured at edge k appears on ser_o after edge k+W-1 and remains there until edge k+W.
- R6: div_word_o is 0 after reset. After edge e it is 1 exactly when (e mod W) >= W/2, so it falls at each edge that loads a word.
- R7: div_pair_o is 0 after reset. After edge e it is 1 exactly when (e mod 2W) >= W, so it falls at every second word load.
- R8: While rst_i is high at a rising edge, the shift chain, par_o, ser_o, div_word_o and div_pair_o all clear to 0, and the edge count for R2, R6 and R7 restarts.
- R9: Suppose a second instance takes the first's ser_o as line_i and shares the clock and reset. Then after each load edge L, {second par_o, first par_o} holds the bits captured at edges L-2W+1 through L, earliest in bit 2W-1. Bits from before reset read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| loop_sel_i | input | 1 | 1 = convert loop_i, 0 = convert line_i |
| line_i | input | 1 | Normal serial data input |
| loop_i | input | 1 | Loopback serial data input |
| par_o | output | W | Parallel word, earliest bit in the MSB |
| div_word_o | output | 1 | Bit clock divided by W |
| div_pair_o | output | 1 | Bit clock divided by 2W |
| ser_o | output | 1 | Registered serial pass-through for chaining |

## Verification
A wrong phase in the divider counter would first appear on div_word_o and div_pair_o, one edge after the fault. The word register would then load at the wrong time, so par_o would hold a rotated word by the next word boundary, at most W edges later. A corrupted shift stage shows up on par_o at the next load. It also shows up on ser_o within W edges, and that corrupts the chained instance's half W edges after that. A broken source select shows as soon as the line and loop inputs carry different data. The bench gives them complementary streams for this reason.

// File: rtl/s2p_pkg.sv
package s2p_pkg;
  localparam int unsigned S2P_DEF_W = 4;

  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_LOOP = 1'b1
  } s2p_src_e;
endpackage

// File: rtl/s2p_bit_select.sv
module s2p_bit_select
  import s2p_pkg::*;
(
  input  logic sel_i,
  input  logic line_i,
  input  logic loop_i,
  output logic bit_o
);
  s2p_src_e src;

  always_comb begin
    src = s2p_src_e'(sel_i);
    unique case (src)
      SRC_LOOP: bit_o = loop_i;
      default:  bit_o = line_i;
    endcase
  end
endmodule

// File: rtl/s2p_shift_chain.sv
module s2p_shift_chain #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         bit_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] nxt_o,
  output logic         tail_o
);
  logic [W-1:0] stage_q;

  // stage 0 receives the newest bit; stage W-1 holds the oldest
  assign nxt_o[0] = bit_i;
  for (genvar g = 1; g < W; g++) begin : g_link
    assign nxt_o[g] = stage_q[g-1];
  end

  for (genvar g = 0; g < W; g++) begin : g_stage
    always_ff @(posedge clk_i) begin
      if (rst_i) stage_q[g] <= 1'b0;
      else       stage_q[g] <= nxt_o[g];
    end
  end

  assign cur_o  = stage_q;
  assign tail_o = stage_q[W-1];
endmodule

// File: rtl/s2p_phase_div.sv
module s2p_phase_div #(
  parameter int W = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  output logic load_o,
  output logic div_word_o,
  output logic div_pair_o
);
  localparam int CW = $clog2(2 * W);
  localparam logic [CW-1:0] LAST  = CW'(2 * W - 1);
  localparam logic [CW-1:0] HALF  = CW'(W);
  localparam logic [CW-1:0] WLAST = CW'(W - 1);
  localparam logic [CW-1:0] WMID  = CW'(W / 2);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d, pos_q, pos_d;
  logic          word_q, pair_q;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + ONE;
    pos_q = (cnt_q >= HALF) ? cnt_q - HALF : cnt_q;
    pos_d = (cnt_d >= HALF) ? cnt_d - HALF : cnt_d;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      word_q <= 1'b0;
      pair_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      word_q <= (pos_d >= WMID);
      pair_q <= (cnt_d >= HALF);
    end
  end

  assign load_o     = (pos_q == WLAST);
  assign div_word_o = word_q;
  assign div_pair_o = pair_q;

  AST_PAIR_ON_WORD_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(div_pair_o) |-> $fell(div_word_o)); // R7
endmodule

// File: rtl/s2p_word_hold.sv
module s2p_word_hold #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] par_o
);
  logic [W-1:0] par_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       par_q <= '0;
    else if (load_i) par_q <= word_i;
  end

  assign par_o = par_q;

  AST_HOLD_BETWEEN_LOADS: assert property (@(posedge clk_i) disable iff (rst_i)
    !load_i |=> $stable(par_o)); // R2
endmodule

// File: rtl/ser2par_cascade.sv
module ser2par_cascade #(
  parameter int W = s2p_pkg::S2P_DEF_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         loop_sel_i,
  input  logic         line_i,
  input  logic         loop_i,
  output logic [W-1:0] par_o,
  output logic         div_word_o,
  output logic         div_pair_o,
  output logic         ser_o
);
  logic         sel_bit;
  logic         load;
  logic [W-1:0] chain_cur, chain_nxt;

  s2p_bit_select u_sel (
    .sel_i (loop_sel_i),
    .line_i(line_i),
    .loop_i(loop_i),
    .bit_o (sel_bit)
  );

  s2p_shift_chain #(.W(W)) u_chain (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .bit_i (sel_bit),
    .cur_o (chain_cur),
    .nxt_o (chain_nxt),
    .tail_o(ser_o)
  );

  s2p_phase_div #(.W(W)) u_div (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_o    (load),
    .div_word_o(div_word_o),
    .div_pair_o(div_pair_o)
  );

  s2p_word_hold #(.W(W)) u_hold (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(load),
    .word_i(chain_nxt),
    .par_o (par_o)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (par_o == '0 && !ser_o && !div_word_o && !div_pair_o)); // R8
  AST_LOAD_MATCHES_CHAIN: assert property (@(posedge clk_i) disable iff (rst_i)
    load |=> (par_o == chain_cur)); // R1
  AST_WORD_CHANGE_ON_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
    !$stable(par_o) |-> $fell(div_word_o)); // R6
endmodule

// File: tb/tb_ser2par_cascade.sv
module tb_ser2par_cascade;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0, line = 1'b0, loop = 1'b0;
  logic [W-1:0] par_lo, par_hi;
  logic dw_lo, dp_lo, ser_lo, dw_hi, dp_hi, ser_hi;

  int n_cmp = 0;
  int n_bad = 0;
  int edge_n = 0;
  logic [2*W-1:0] win = '0;
  logic [W-1:0] exp_par = '0;
  logic [2*W-1:0] exp_pair = '0;
  string load_tag = "R1";

  always #10 clk = ~clk;

  ser2par_cascade #(.W(W)) dut (
    .clk_i(clk), .rst_i(rst), .loop_sel_i(sel), .line_i(line), .loop_i(loop),
    .par_o(par_lo), .div_word_o(dw_lo), .div_pair_o(dp_lo), .ser_o(ser_lo));

  ser2par_cascade #(.W(W)) hi (
    .clk_i(clk), .rst_i(rst), .loop_sel_i(1'b0), .line_i(ser_lo), .loop_i(1'b0),
    .par_o(par_hi), .div_word_o(dw_hi), .div_pair_o(dp_hi), .ser_o(ser_hi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, edge_n);
    end
  endtask

  task automatic check_all();
    logic is_load;
    is_load = (edge_n % W == 0);
    chk(is_load ? load_tag : "R2", 32'(par_lo), 32'(exp_par));
    chk("R5", 32'(ser_lo), 32'(win[W-1]));
    chk("R6", 32'(dw_lo), 32'((edge_n % W) >= W / 2));
    chk("R7", 32'(dp_lo), 32'((edge_n % (2 * W)) >= W));
    if (is_load) chk("R9", 32'({par_hi, par_lo}), 32'(exp_pair));
  endtask

  // one bit time: drive away from the edge, sample 2 ns after it
  task automatic step(input logic s, input logic l, input logic p);
    logic b;
    sel = s; line = l; loop = p;
    b = s ? p : l;
    @(posedge clk);
    #2;
    edge_n++;
    win = {win[2*W-2:0], b};
    if (edge_n % W == 0) begin
      exp_par  = win[W-1:0];
      exp_pair = win;
    end
    check_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    #2;
    rst = 1'b0;
    edge_n = 0; win = '0; exp_par = '0; exp_pair = '0;
    chk("R8", 32'(par_lo), 0);
    chk("R8", 32'(ser_lo), 0);
    chk("R8", 32'(dw_lo), 0);
    chk("R8", 32'(dp_lo), 0);
    chk("R8", 32'(par_hi), 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    #2;
    @(posedge clk); #2;
    do_reset();

    // R1 R9: every byte value on the line input, loop input carrying its complement
    load_tag = "R1";
    for (int v = 0; v < 256; v++)
      for (int i = 2 * W - 1; i >= 0; i--)
        step(1'b0, v[i], ~v[i]);

    // R3: every byte value on the loop input, line carrying the complement
    load_tag = "R3";
    for (int v = 0; v < 256; v++)
      for (int i = 2 * W - 1; i >= 0; i--)
        step(1'b1, ~v[i], v[i]);

    // R4: select toggling in all 4-bit patterns against pseudo-random data
    load_tag = "R4";
    lfsr = 16'hACE1;
    for (int v = 0; v < 16; v++)
      for (int r = 0; r < 16; r++)
        for (int i = W - 1; i >= 0; i--) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          step(v[i], lfsr[0], lfsr[5]);
        end

    // R8: reset in the middle of a word, then realign and run on
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0);
    do_reset();
    load_tag = "R1";
    for (int v = 0; v < 64; v++)
      for (int i = 2 * W - 1; i >= 0; i--)
        step(1'b0, v[i] ^ v[0], 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule